// File: doc/BRIEF.md
# Record Slot Map Manager

This block owns a fixed table of record slots used by a persistent error-log store. Each slot holds a 64-bit record identifier, and a counter tracks how many slots are occupied. A controller issues one command at a time through a start/done handshake: store an identifier, look one up for reading, release one, or walk the stored identifiers in slot order. The block only decides which slot a command resolves to and keeps the table and counter consistent. Moving record payloads and checking their contents happens elsewhere.

An identifier of all zeros marks a free slot, and all ones marks the end of an enumeration. Slots below a configurable first index are reserved and never used. A returned index of 0 means no slot. The table is scanned one entry per clock cycle. A lookup stops as soon as it has passed as many occupied entries as the counter holds. An enumeration cursor is kept between commands.

Top module: `slot_map_mgr`

## Requirements
- R1: A command is accepted only on a cycle where `cmd_start` is high and `cmd_busy` is low, and a start while busy is ignored. Each accepted command produces exactly one single-cycle `cmd_done` pulse. The status, index and identifier outputs are valid in that cycle and are held until the next pulse. Operation codes on `cmd_op`: 0 store, 1 read, 2 release, 3 next identifier.
- R2: Usable slots run from `FIRST_IDX` to `NUM_SLOTS-1`. A returned index is either 0 (no slot) or lies in that range. Any nonzero status returns index 0. Status codes: 0 success, 1 table full, 3 failed, 4 table empty, 5 not found.
- R3: A store whose identifier is all zeros or all ones returns status 3. It leaves the table and counter unchanged.
- R4: A store of an identifier not in the table takes the lowest-numbered free usable slot, increments the counter and returns status 0 with that slot. When no slot is free it returns status 1 and the counter is unchanged.
- R5: A store of an identifier already in the table reuses that slot, returns status 0 with its index, and leaves the counter unchanged.
- R6: A release with an all-zeros or all-ones identifier returns status 3. A release of a stored identifier frees its slot, decrements the counter, and returns status 0 with that slot. A release of an absent identifier returns status 5.
- R7: Next identifier with `cmd_first` high restarts at `FIRST_IDX`. It returns the identifier in the next occupied slot at or above the cursor, with that slot as index, and moves the cursor past it. When none remains it returns all ones with index 0 and rewinds the cursor to `FIRST_IDX`. Its status is always 0.
- R8: Next identifier with an empty table returns all ones, index 0, status 0, and rewinds the cursor.
- R9: A read returns status 4 when the counter is 0, and status 3 when the identifier is all ones. It returns status 5 when the identifier is not found, with the searched identifier echoed. On a hit it returns status 0, the slot of the hit, and the identifier stored in the lowest occupied slot, and leaves the cursor just past that lowest occupied slot.
- R10: A read with an all-zeros identifier first resolves it to the identifier in the lowest occupied slot, then proceeds as R9.
- R11: Reset clears `cmd_done`, `cmd_busy` and the status output, and rewinds the cursor to `FIRST_IDX`. Table contents and the counter survive reset. Both start at zero after power-up.
- R12: The table and counter change only on the edge that raises `cmd_done`, by at most one slot and one count step. A command started in the `cmd_done` cycle sees the updated state. `rec_count` shows the counter.
- R13: A slot freed by a release is the first one reused by the next store of a new identifier when it is the lowest free slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| cmd_start | input | 1 | Command request |
| cmd_op | input | 2 | Operation code (R1) |
| cmd_id | input | ID_W | Identifier operand |
| cmd_first | input | 1 | Restart enumeration (next identifier only) |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_status | output | 3 | Result status code (R2) |
| cmd_index | output | IDX_W | Resolved slot, 0 when none |
| cmd_id_out | output | ID_W | Identifier result |
| rec_count | output | COUNT_W | Occupied-slot counter |

## Verification
A wrong slot entry or counter value shows at the ports on the very next command that touches it. A store lands in the wrong slot, a release reports status 5, or an enumeration yields a wrong identifier. `rec_count` exposes counter drift in the done cycle itself. A corrupted cursor first shows on the next next-identifier command without the restart flag, which returns an identifier out of slot order. Because lookups stop on the occupied count, an off-by-one counter also turns a stored identifier into a status-5 miss within one command.

// File: rtl/slot_map_pkg.sv
package slot_map_pkg;

    typedef enum logic [1:0] {
        OP_STORE = 2'd0,
        OP_READ  = 2'd1,
        OP_FREE  = 2'd2,
        OP_NEXT  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RS_OK        = 3'd0,
        RS_FULL      = 3'd1,
        RS_FAILED    = 3'd3,
        RS_EMPTY     = 3'd4,
        RS_NOT_FOUND = 3'd5
    } res_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOOK  = 2'd1,
        PH_ALLOC = 2'd2,
        PH_WALK  = 2'd3
    } phase_e;

endpackage

// File: rtl/slot_map_store.sv
module slot_map_store #(
    parameter int NUM_SLOTS = 16,
    parameter int FIRST_IDX = 1,
    parameter int ID_W      = 64,
    parameter int COUNT_W   = 32,
    parameter int IDX_W     = 5
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ID_W-1:0]    wr_val,
    input  logic               cnt_inc,
    input  logic               cnt_dec,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ID_W-1:0]    rd_data,
    output logic [COUNT_W-1:0] count
);

    logic [ID_W-1:0] ent [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (g < FIRST_IDX) begin : g_rsv
            assign ent[g] = '0;
        end else begin : g_live
            logic [ID_W-1:0] slot_q = '0;
            always_ff @(posedge clk) begin
                if (wr_en && (wr_idx == IDX_W'(g))) begin
                    slot_q <= wr_val;
                end
            end
            assign ent[g] = slot_q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = ent[i];
            end
        end
    end

    logic [COUNT_W-1:0] cnt_q = '0;
    logic [COUNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_inc) begin
            cnt_d = cnt_q + COUNT_W'(1);
        end else if (cnt_dec) begin
            cnt_d = cnt_q - COUNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/slot_map_ctrl.sv
module slot_map_ctrl
    import slot_map_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int FIRST_IDX = 1,
    parameter int ID_W      = 64,
    parameter int COUNT_W   = 32,
    parameter int IDX_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         op_i,
    input  logic [ID_W-1:0]    id_i,
    input  logic               first_i,
    input  logic [COUNT_W-1:0] count_i,
    input  logic [ID_W-1:0]    rd_data_i,
    output logic [IDX_W-1:0]   rd_idx_o,
    output logic               wr_en_o,
    output logic [IDX_W-1:0]   wr_idx_o,
    output logic [ID_W-1:0]    wr_val_o,
    output logic               cnt_inc_o,
    output logic               cnt_dec_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [2:0]         status_o,
    output logic [IDX_W-1:0]   index_o,
    output logic [ID_W-1:0]    id_out_o
);

    localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(FIRST_IDX);
    localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(NUM_SLOTS);
    localparam logic [ID_W-1:0]  END_ID  = '1;

    typedef struct packed {
        phase_e             ph;
        op_e                op;
        logic [ID_W-1:0]    id;
        logic [IDX_W-1:0]   idx;
        logic [COUNT_W-1:0] seen;
        logic [IDX_W-1:0]   cursor;
        logic [IDX_W-1:0]   hit;
        logic               after;
        logic               done;
        res_e               res;
        logic [IDX_W-1:0]   index;
        logic [ID_W-1:0]    id_out;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    function automatic logic id_usable(input logic [ID_W-1:0] v);
        return (v != '0) && (v != '1);
    endfunction

    function automatic ctl_t finish(input ctl_t s, input res_e r,
                                    input logic [IDX_W-1:0] ix,
                                    input logic [ID_W-1:0] idv);
        ctl_t t;
        t        = s;
        t.ph     = PH_IDLE;
        t.done   = 1'b1;
        t.res    = r;
        t.index  = ix;
        t.id_out = idv;
        return t;
    endfunction

    logic scan_end;
    logic count_hit;
    op_e  op_in;

    assign scan_end  = (ctl_q.idx >= LAST_I);
    assign count_hit = (ctl_q.seen >= count_i);
    assign op_in     = op_e'(op_i);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        wr_en_o    = 1'b0;
        wr_idx_o   = ctl_q.idx;
        wr_val_o   = ctl_q.id;
        cnt_inc_o  = 1'b0;
        cnt_dec_o  = 1'b0;

        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    ctl_d.op    = op_in;
                    ctl_d.id    = id_i;
                    ctl_d.idx   = FIRST_I;
                    ctl_d.seen  = '0;
                    ctl_d.after = 1'b0;
                    unique case (op_in)
                        OP_STORE, OP_FREE: begin
                            if (!id_usable(id_i)) begin
                                ctl_d = finish(ctl_d, RS_FAILED, '0, id_i);
                            end else begin
                                ctl_d.ph = PH_LOOK;
                            end
                        end
                        OP_READ: begin
                            if (count_i == '0) begin
                                ctl_d = finish(ctl_d, RS_EMPTY, '0, id_i);
                            end else if (id_i == END_ID) begin
                                ctl_d = finish(ctl_d, RS_FAILED, '0, id_i);
                            end else if (id_i == '0) begin
                                ctl_d.ph = PH_WALK;
                            end else begin
                                ctl_d.ph = PH_LOOK;
                            end
                        end
                        OP_NEXT: begin
                            if (count_i == '0) begin
                                ctl_d.cursor = FIRST_I;
                                ctl_d = finish(ctl_d, RS_OK, '0, END_ID);
                            end else begin
                                ctl_d.idx = first_i ? FIRST_I : ctl_q.cursor;
                                ctl_d.ph  = PH_WALK;
                            end
                        end
                        default: ;
                    endcase
                end
            end

            PH_LOOK: begin
                if (scan_end || count_hit) begin
                    if (ctl_q.op == OP_STORE) begin
                        ctl_d.ph  = PH_ALLOC;
                        ctl_d.idx = FIRST_I;
                    end else begin
                        ctl_d = finish(ctl_d, RS_NOT_FOUND, '0, ctl_q.id);
                    end
                end else if (rd_data_i == ctl_q.id) begin
                    unique case (ctl_q.op)
                        OP_STORE: begin
                            wr_en_o = 1'b1;
                            ctl_d   = finish(ctl_d, RS_OK, ctl_q.idx, ctl_q.id);
                        end
                        OP_FREE: begin
                            wr_en_o   = 1'b1;
                            wr_val_o  = '0;
                            cnt_dec_o = 1'b1;
                            ctl_d     = finish(ctl_d, RS_OK, ctl_q.idx, ctl_q.id);
                        end
                        default: begin
                            ctl_d.hit   = ctl_q.idx;
                            ctl_d.after = 1'b1;
                            ctl_d.ph    = PH_WALK;
                            ctl_d.idx   = FIRST_I;
                        end
                    endcase
                end else begin
                    if (rd_data_i != '0) begin
                        ctl_d.seen = ctl_q.seen + COUNT_W'(1);
                    end
                    ctl_d.idx = ctl_q.idx + IDX_W'(1);
                end
            end

            PH_ALLOC: begin
                if (scan_end) begin
                    ctl_d = finish(ctl_d, RS_FULL, '0, ctl_q.id);
                end else if (rd_data_i == '0) begin
                    wr_en_o   = 1'b1;
                    cnt_inc_o = 1'b1;
                    ctl_d     = finish(ctl_d, RS_OK, ctl_q.idx, ctl_q.id);
                end else begin
                    ctl_d.idx = ctl_q.idx + IDX_W'(1);
                end
            end

            PH_WALK: begin
                if (scan_end) begin
                    ctl_d.cursor = FIRST_I;
                    if (ctl_q.op != OP_READ) begin
                        ctl_d = finish(ctl_d, RS_OK, '0, END_ID);
                    end else if (ctl_q.after) begin
                        ctl_d = finish(ctl_d, RS_OK, ctl_q.hit, END_ID);
                    end else begin
                        ctl_d = finish(ctl_d, RS_FAILED, '0, END_ID);
                    end
                end else if (rd_data_i != '0) begin
                    ctl_d.cursor = ctl_q.idx + IDX_W'(1);
                    if (ctl_q.op != OP_READ) begin
                        ctl_d = finish(ctl_d, RS_OK, ctl_q.idx, rd_data_i);
                    end else if (ctl_q.after) begin
                        ctl_d = finish(ctl_d, RS_OK, ctl_q.hit, rd_data_i);
                    end else begin
                        ctl_d.id   = rd_data_i;
                        ctl_d.ph   = PH_LOOK;
                        ctl_d.idx  = FIRST_I;
                        ctl_d.seen = '0;
                    end
                end else begin
                    ctl_d.idx = ctl_q.idx + IDX_W'(1);
                end
            end

            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.ph     <= PH_IDLE;
            ctl_q.op     <= OP_STORE;
            ctl_q.res    <= RS_OK;
            ctl_q.cursor <= FIRST_I;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_idx_o = ctl_q.idx;
    assign busy_o   = (ctl_q.ph != PH_IDLE);
    assign done_o   = ctl_q.done;
    assign status_o = ctl_q.res;
    assign index_o  = ctl_q.index;
    assign id_out_o = ctl_q.id_out;

endmodule

// File: rtl/slot_map_mgr.sv
module slot_map_mgr #(
    parameter  int NUM_SLOTS = 16,
    parameter  int FIRST_IDX = 1,
    parameter  int ID_W      = 64,
    parameter  int COUNT_W   = 32,
    localparam int IDX_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [1:0]         cmd_op,
    input  logic [ID_W-1:0]    cmd_id,
    input  logic               cmd_first,
    output logic               cmd_busy,
    output logic               cmd_done,
    output logic [2:0]         cmd_status,
    output logic [IDX_W-1:0]   cmd_index,
    output logic [ID_W-1:0]    cmd_id_out,
    output logic [COUNT_W-1:0] rec_count
);

    logic [IDX_W-1:0]   rd_idx;
    logic [ID_W-1:0]    rd_data;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic [ID_W-1:0]    wr_val;
    logic               cnt_inc;
    logic               cnt_dec;
    logic [COUNT_W-1:0] count;

    slot_map_ctrl #(
        .NUM_SLOTS (NUM_SLOTS),
        .FIRST_IDX (FIRST_IDX),
        .ID_W      (ID_W),
        .COUNT_W   (COUNT_W),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cmd_start),
        .op_i      (cmd_op),
        .id_i      (cmd_id),
        .first_i   (cmd_first),
        .count_i   (count),
        .rd_data_i (rd_data),
        .rd_idx_o  (rd_idx),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_val_o  (wr_val),
        .cnt_inc_o (cnt_inc),
        .cnt_dec_o (cnt_dec),
        .busy_o    (cmd_busy),
        .done_o    (cmd_done),
        .status_o  (cmd_status),
        .index_o   (cmd_index),
        .id_out_o  (cmd_id_out)
    );

    slot_map_store #(
        .NUM_SLOTS (NUM_SLOTS),
        .FIRST_IDX (FIRST_IDX),
        .ID_W      (ID_W),
        .COUNT_W   (COUNT_W),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val),
        .cnt_inc (cnt_inc),
        .cnt_dec (cnt_dec),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .count   (count)
    );

    assign rec_count = count;

endmodule

// File: rtl/slot_map_mgr_chk.sv
module slot_map_mgr_chk #(
    parameter int NUM_SLOTS = 16,
    parameter int FIRST_IDX = 1,
    parameter int COUNT_W   = 32,
    parameter int IDX_W     = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_busy,
    input logic               cmd_done,
    input logic [2:0]         cmd_status,
    input logic [IDX_W-1:0]   cmd_index,
    input logic [COUNT_W-1:0] rec_count
);

    logic past_ok = 1'b0;
    always_ff @(posedge clk) begin
        past_ok <= 1'b1;
    end

    a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !cmd_busy);

    a_r2_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (cmd_status inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd5}));

    a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_index != '0) |->
            (cmd_index >= IDX_W'(FIRST_IDX) && cmd_index < IDX_W'(NUM_SLOTS)));

    a_r2_fail_no_index: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_status != 3'd0) |-> (cmd_index == '0));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rec_count <= COUNT_W'(NUM_SLOTS - FIRST_IDX));

    a_r12_count_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rec_count != $past(rec_count)) |-> cmd_done);

    a_r12_count_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rec_count == $past(rec_count) ||
                     rec_count == $past(rec_count) + COUNT_W'(1) ||
                     rec_count == $past(rec_count) - COUNT_W'(1)));

endmodule

bind slot_map_mgr slot_map_mgr_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .FIRST_IDX (FIRST_IDX),
    .COUNT_W   (COUNT_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_busy   (cmd_busy),
    .cmd_done   (cmd_done),
    .cmd_status (cmd_status),
    .cmd_index  (cmd_index),
    .rec_count  (rec_count)
);

// File: tb/test_slot_map_mgr.sv
`timescale 1ns/1ps
module test_slot_map_mgr;

    localparam int NS  = 6;
    localparam int FI  = 2;
    localparam int IW  = 64;
    localparam int CW  = 32;
    localparam int XW  = $clog2(NS + 1);
    localparam logic [63:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [IW-1:0] cmd_id = '0;
    logic          cmd_first = 1'b0;
    logic          cmd_busy;
    logic          cmd_done;
    logic [2:0]    cmd_status;
    logic [XW-1:0] cmd_index;
    logic [IW-1:0] cmd_id_out;
    logic [CW-1:0] rec_count;

    always #5 clk = ~clk;

    slot_map_mgr #(.NUM_SLOTS(NS), .FIRST_IDX(FI), .ID_W(IW), .COUNT_W(CW)) i_slot_map_mgr (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_id(cmd_id), .cmd_first(cmd_first), .cmd_busy(cmd_busy),
        .cmd_done(cmd_done), .cmd_status(cmd_status), .cmd_index(cmd_index),
        .cmd_id_out(cmd_id_out), .rec_count(rec_count)
    );

    int tests = 0;
    int fails = 0;

    logic [63:0] mmap [NS];
    int mcnt = 0;
    int mcur = FI;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic bit usable(input logic [63:0] v);
        return (v != 64'd0) && (v != ONES);
    endfunction

    function automatic int m_lookup(input logic [63:0] v);
        int seen = 0;
        if (v == 64'd0) return 0;
        for (int i = FI; i < NS && seen < mcnt; i++) begin
            if (mmap[i] == v) return i;
            if (mmap[i] != 64'd0) seen++;
        end
        return 0;
    endfunction

    task automatic m_next(input bit first, output logic [63:0] v, output int ix);
        if (first) mcur = FI;
        v = ONES;
        ix = 0;
        if (mcnt != 0) begin
            for (int i = mcur; i < NS; i++) begin
                if (mmap[i] != 64'd0) begin
                    v = mmap[i];
                    ix = i;
                    mcur = i + 1;
                    return;
                end
            end
        end
        mcur = FI;
    endtask

    task automatic predict(input int op, input logic [63:0] id, input bit first,
                           output int est, output int eix, output logic [63:0] eid);
        int i;
        int j;
        logic [63:0] r;
        logic [63:0] f;
        int dummy;
        est = 0; eix = 0; eid = id;
        case (op)
            0: begin
                if (!usable(id)) est = 3;
                else begin
                    i = m_lookup(id);
                    if (i != 0) eix = i;
                    else begin
                        j = 0;
                        for (int k = FI; k < NS; k++) if (j == 0 && mmap[k] == 64'd0) j = k;
                        if (j == 0) est = 1;
                        else begin mmap[j] = id; mcnt++; eix = j; end
                    end
                end
            end
            2: begin
                if (!usable(id)) est = 3;
                else begin
                    i = m_lookup(id);
                    if (i == 0) est = 5;
                    else begin mmap[i] = 64'd0; mcnt--; eix = i; end
                end
            end
            1: begin
                if (mcnt == 0) est = 4;
                else begin
                    r = id;
                    if (r == 64'd0) m_next(1'b1, r, dummy);
                    if (r == ONES) begin est = 3; eid = ONES; end
                    else begin
                        i = m_lookup(r);
                        if (i == 0) begin est = 5; eid = r; end
                        else begin m_next(1'b1, f, dummy); eix = i; eid = f; end
                    end
                end
            end
            default: m_next(first, eid, eix);
        endcase
    endtask

    // Entered at a negedge; returns at the negedge where cmd_done is seen.
    task automatic do_cmd(input string req, input int op, input logic [63:0] id, input bit first);
        int est, eix;
        logic [63:0] eid;
        predict(op, id, first, est, eix, eid);
        cmd_start = 1'b1; cmd_op = op[1:0]; cmd_id = id; cmd_first = first;
        @(negedge clk);
        cmd_start = 1'b0;
        while (!cmd_done) @(negedge clk);
        chk({req, " status"}, 64'(cmd_status), 64'(est));
        chk({req, " index"},  64'(cmd_index),  64'(eix));
        chk({req, " id"},     cmd_id_out,      eid);
        chk({req, " count"},  64'(rec_count),  64'(mcnt));
    endtask

    localparam logic [63:0] A = 64'h11, B = 64'h22, C = 64'h33, D = 64'h44, E = 64'h55;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int est, eix;
        logic [63:0] eid;
        for (int i = 0; i < NS; i++) mmap[i] = 64'd0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 done in reset", 64'(cmd_done), 64'd0);
        chk("R11 busy in reset", 64'(cmd_busy), 64'd0);
        chk("R11 status in reset", 64'(cmd_status), 64'd0);
        chk("R11 count at power-up", 64'(rec_count), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        do_cmd("R8 next on empty", 3, 64'd0, 1'b1);
        do_cmd("R9 read on empty", 1, A, 1'b0);
        do_cmd("R3 store zero id", 0, 64'd0, 1'b0);
        do_cmd("R3 store ones id", 0, ONES, 1'b0);
        do_cmd("R4 store A", 0, A, 1'b0);
        do_cmd("R4 store B", 0, B, 1'b0);
        do_cmd("R4 store C", 0, C, 1'b0);
        do_cmd("R5 store B again", 0, B, 1'b0);
        do_cmd("R4 store D", 0, D, 1'b0);
        do_cmd("R4 store E full", 0, E, 1'b0);
        do_cmd("R7 next first", 3, 64'd0, 1'b1);
        do_cmd("R7 next 2", 3, 64'd0, 1'b0);
        do_cmd("R7 next 3", 3, 64'd0, 1'b0);
        do_cmd("R7 next 4", 3, 64'd0, 1'b0);
        do_cmd("R7 next end", 3, 64'd0, 1'b0);
        do_cmd("R7 next after rewind", 3, 64'd0, 1'b0);
        do_cmd("R6 free B", 2, B, 1'b0);
        do_cmd("R6 free B absent", 2, B, 1'b0);
        do_cmd("R6 free zero id", 2, 64'd0, 1'b0);
        do_cmd("R6 free ones id", 2, ONES, 1'b0);
        do_cmd("R13 store E reuses slot", 0, E, 1'b0);
        do_cmd("R9 read C hit", 1, C, 1'b0);
        do_cmd("R9 cursor after read", 3, 64'd0, 1'b0);
        do_cmd("R9 read absent", 1, 64'h99, 1'b0);
        do_cmd("R10 read zero id", 1, 64'd0, 1'b0);
        do_cmd("R9 read ones id", 1, ONES, 1'b0);

        // R1: start while busy is ignored, done is a single pulse
        predict(1, D, 1'b0, est, eix, eid);
        cmd_start = 1'b1; cmd_op = 2'd1; cmd_id = D; cmd_first = 1'b0;
        @(negedge clk);
        chk("R1 busy after start", 64'(cmd_busy), 64'd1);
        cmd_op = 2'd2; cmd_id = A;
        @(negedge clk);
        cmd_start = 1'b0;
        while (!cmd_done) @(negedge clk);
        chk("R1 first command status", 64'(cmd_status), 64'(est));
        chk("R1 first command index", 64'(cmd_index), 64'(eix));
        chk("R1 first command id", cmd_id_out, eid);
        @(negedge clk);
        chk("R1 done single cycle", 64'(cmd_done), 64'd0);
        chk("R1 outputs held", 64'(cmd_index), 64'(eix));
        chk("R1 ignored free left count", 64'(rec_count), 64'(mcnt));
        do_cmd("R1 A still stored", 0, A, 1'b0);

        // R11: reset keeps table and count, rewinds cursor
        do_cmd("R11 advance cursor", 3, 64'd0, 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 done cleared", 64'(cmd_done), 64'd0);
        chk("R11 count kept", 64'(rec_count), 64'(mcnt));
        rst_n = 1'b1;
        mcur = FI;
        @(negedge clk);
        do_cmd("R11 cursor rewound", 3, 64'd0, 1'b0);

        // R4 R6 R7 R12: sweep of back-to-back mixed traffic
        for (int rnd = 0; rnd < 8; rnd++) begin
            for (int k = 0; k < NS; k++) begin
                do_cmd("R12 sweep store", 0, 64'(rnd * 16 + k + 1), 1'b0);
                do_cmd("R6 sweep free", 2, 64'(rnd * 16 + ((k * 3) % NS) + 1), 1'b0);
            end
            do_cmd("R7 sweep walk first", 3, 64'd0, 1'b1);
            for (int k = 0; k < NS; k++) do_cmd("R7 sweep walk", 3, 64'd0, 1'b0);
            do_cmd("R9 sweep read", 1, 64'(rnd * 16 + 2), 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule